// File: doc/BRIEF.md
# Slotted Video Write FIFO

This block buffers CPU data-port writes headed for three video memories (pattern RAM, color RAM and scroll RAM). It holds up to four pending words. Each word carries the time at which it becomes eligible to leave. The block releases at most one memory access per access slot. A slot is a one-cycle strobe from the display timing logic. The head word leaves only when a slot arrives and its eligible time is at or before the current time.

The block owns the destination address. The control-port logic loads the address, and the block advances it by an auto-increment amount after every completed access. A 4-bit command code selects the destination memory. Pattern RAM is byte-wide, so a pattern word takes two slots: the high byte goes to the address, then the low byte goes to the address with bit 0 inverted.

When DMA is enabled and the DMA command bit is set, the head word is not written. It is latched as the fill value for a DMA engine outside this block, and a run flag is raised. While that flag is set, slots belong to the DMA engine and the FIFO keeps its contents. The block reports FIFO-full on bit 8 of a status word and refuses pushes while full.

Top module: `slot_write_queue`

## Requirements
- R1: After reset the FIFO is empty, `statusWord` is 0, `pushReady` is 1, `dmaRun` is 0, `curAddr` is 0 and no write is issued.
- R2: A head entry is used only in a cycle with `slotEn` high, `dmaRun` low, the FIFO non-empty and the entry's ready time less than or equal to `cycleNow`. In every other cycle with `slotEn` high and `dmaRun` low, `slotUnused` is 1 and no write is issued.
- R3: With `cmdLow` = 3 (color) or 5 (scroll), a used entry produces one word write. `wrTarget` is 1 for color and 2 for scroll, `wrByte` is 0, `wrAddr` equals `curAddr` and `wrData` equals the entry value. The entry is then removed and `curAddr` grows by `autoInc`.
- R4: With `cmdLow` = 1 (pattern, `wrTarget` = 0), the first slot on an entry writes the high byte in `wrData[7:0]` at `curAddr`, with `wrByte` = 1. The entry and the address are kept. The next used slot writes the low byte at `curAddr` XOR 1, then removes the entry and adds `autoInc`.
- R5: With any other `cmdLow` value, a used entry issues no write, but it is still removed and the address is still advanced by `autoInc`.
- R6: If `dmaEnable` and `cmdDma` are both 1 when an entry is used, no write is issued. The value goes to `fillValue`, `dmaRun` becomes 1, the entry is removed and `curAddr` is unchanged. With `dmaEnable` low, `cmdDma` has no effect.
- R7: While `dmaRun` is 1, no entry is drained, `dmaSlot` follows `slotEn`, and `slotUnused` stays 0. A `dmaDone` pulse clears `dmaRun`.
- R8: `statusWord[8]` is 1 exactly when DEPTH entries are held. All other bits of `statusWord` are 0.
- R9: `pushReady` is 0 while the FIFO is full. A push offered then is dropped and is never written.
- R10: `addrLoad` replaces `curAddr` with `addrLoadValue` and takes priority over the increment.
- R11: Entries leave in push order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cycleNow | input | TW | Current time |
| pushValid | input | 1 | Data-port write offered |
| pushData | input | 16 | Value to buffer |
| pushTime | input | TW | Ready time of the offered value |
| pushReady | output | 1 | Push accepted this cycle |
| slotEn | input | 1 | Memory access slot strobe |
| cmdLow | input | 4 | Destination command code |
| cmdDma | input | 1 | DMA start command bit |
| dmaEnable | input | 1 | DMA enabled by the mode register |
| dmaDone | input | 1 | DMA engine finished, clears the run flag |
| autoInc | input | 8 | Address auto-increment amount |
| addrLoad | input | 1 | Load a new destination address |
| addrLoadValue | input | AW | Address to load |
| curAddr | output | AW | Current destination address |
| wrEn | output | 1 | Memory write strobe |
| wrTarget | output | 2 | 0 pattern, 1 color, 2 scroll |
| wrByte | output | 1 | Byte write (data in bits 7:0) |
| wrAddr | output | AW | Write address |
| wrData | output | 16 | Write data |
| slotUnused | output | 1 | Slot left idle |
| dmaSlot | output | 1 | Slot granted to the DMA engine |
| dmaRun | output | 1 | Pending DMA fill is running |
| fillValue | output | 16 | Latched fill value |
| statusWord | output | 16 | Status, bit 8 is FIFO full |

## Verification
The bench builds the block with its defaults: DEPTH 4, a 16-bit address and a 16-bit time. At these values, four back-to-back pushes with slots held off reach the full flag and a refused fifth push. The time field is also wide enough for the bench to place a ready time several cycles ahead and check that the write lands in exactly that cycle. A scoreboard queue then confirms push order across color, scroll and split pattern writes, and confirms that nothing leaks out while a DMA fill holds the slots.

// File: rtl/swq_pkg.sv
package swq_pkg;
  typedef enum logic [1:0] {
    TGT_PATTERN = 2'd0,
    TGT_COLOR   = 2'd1,
    TGT_SCROLL  = 2'd2
  } wrTarget_t;

  localparam logic [3:0] CMD_PATTERN = 4'd1;
  localparam logic [3:0] CMD_COLOR   = 4'd3;
  localparam logic [3:0] CMD_SCROLL  = 4'd5;

  typedef struct packed {
    logic push;
    logic pop;
    logic incAddr;
    logic latchFill;
    logic setPartial;
    logic wrLow;
    logic wrByte;
  } swqStrobes_t;
endpackage

// File: rtl/swq_ctrl.sv
module swq_ctrl
  import swq_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [TW-1:0] cycleNow,
  input  logic          pushValid,
  input  logic          slotEn,
  input  logic [3:0]    cmdLow,
  input  logic          cmdDma,
  input  logic          dmaEnable,
  input  logic          dmaDone,
  input  logic          headValid,
  input  logic          full,
  input  logic [TW-1:0] headTime,
  input  logic          headPartial,
  output swqStrobes_t   strobes,
  output logic          wrEn,
  output logic [1:0]    wrTarget,
  output logic          slotUnused,
  output logic          dmaSlot,
  output logic          dmaRun
);
  logic headReady;
  logic useHead;
  logic startFill;
  logic normalUse;
  logic isPattern;
  logic isColor;
  logic isScroll;
  logic firstHalf;

  assign headReady = headValid && (headTime <= cycleNow);
  assign useHead   = slotEn && !dmaRun && headReady;
  assign startFill = useHead && dmaEnable && cmdDma;
  assign normalUse = useHead && !startFill;

  assign isPattern = (cmdLow == CMD_PATTERN);
  assign isColor   = (cmdLow == CMD_COLOR);
  assign isScroll  = (cmdLow == CMD_SCROLL);
  assign firstHalf = normalUse && isPattern && !headPartial;

  always_comb begin
    strobes            = '0;
    strobes.push       = pushValid && !full;
    strobes.latchFill  = startFill;
    strobes.setPartial = firstHalf;
    strobes.pop        = startFill || (normalUse && !firstHalf);
    strobes.incAddr    = normalUse && !firstHalf;
    strobes.wrByte     = isPattern;
    strobes.wrLow      = isPattern && headPartial;
  end

  always_comb begin
    wrTarget = TGT_PATTERN;
    if (isColor)  wrTarget = TGT_COLOR;
    if (isScroll) wrTarget = TGT_SCROLL;
  end

  assign wrEn       = normalUse && (isPattern || isColor || isScroll);
  assign slotUnused = slotEn && !dmaRun && !headReady;
  assign dmaSlot    = slotEn && dmaRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          dmaRun <= 1'b0;
    else if (startFill) dmaRun <= 1'b1;
    else if (dmaDone)   dmaRun <= 1'b0;
  end
endmodule

// File: rtl/swq_dp.sv
module swq_dp
  import swq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int TW    = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  swqStrobes_t   strobes,
  input  logic [15:0]   pushData,
  input  logic [TW-1:0] pushTime,
  input  logic [7:0]    autoInc,
  input  logic          addrLoad,
  input  logic [AW-1:0] addrLoadValue,
  output logic          headValid,
  output logic          full,
  output logic [TW-1:0] headTime,
  output logic          headPartial,
  output logic [AW-1:0] curAddr,
  output logic [AW-1:0] wrAddr,
  output logic [15:0]   wrData,
  output logic [15:0]   fillValue
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_COUNT = CW'(DEPTH);
  localparam logic [PW-1:0] LAST_IDX   = PW'(DEPTH - 1);

  logic [15:0]   entryData [DEPTH];
  logic [TW-1:0] entryTime [DEPTH];
  logic [PW-1:0] headPtr;
  logic [PW-1:0] tailPtr;
  logic [CW-1:0] count;
  logic [15:0]   headData;

  for (genvar i = 0; i < DEPTH; i++) begin : gEntry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        entryData[i] <= '0;
        entryTime[i] <= '0;
      end else if (strobes.push && tailPtr == PW'(i)) begin
        entryData[i] <= pushData;
        entryTime[i] <= pushTime;
      end
    end
  end

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headPtr     <= '0;
      tailPtr     <= '0;
      count       <= '0;
      headPartial <= 1'b0;
    end else begin
      if (strobes.push) tailPtr <= nextPtr(tailPtr);
      if (strobes.pop)  headPtr <= nextPtr(headPtr);
      case ({strobes.push, strobes.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (strobes.pop)             headPartial <= 1'b0;
      else if (strobes.setPartial) headPartial <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  curAddr <= '0;
    else if (addrLoad)          curAddr <= addrLoadValue;
    else if (strobes.incAddr)   curAddr <= curAddr + AW'(autoInc);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  fillValue <= '0;
    else if (strobes.latchFill) fillValue <= headData;
  end

  assign headData  = entryData[headPtr];
  assign headTime  = entryTime[headPtr];
  assign headValid = (count != '0);
  assign full      = (count == FULL_COUNT);

  assign wrAddr = strobes.wrLow ? (curAddr ^ AW'(1)) : curAddr;

  always_comb begin
    if (!strobes.wrByte)    wrData = headData;
    else if (strobes.wrLow) wrData = {8'h00, headData[7:0]};
    else                    wrData = {8'h00, headData[15:8]};
  end
endmodule

// File: rtl/slot_write_queue.sv
module slot_write_queue
  import swq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int TW    = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [TW-1:0] cycleNow,
  input  logic          pushValid,
  input  logic [15:0]   pushData,
  input  logic [TW-1:0] pushTime,
  output logic          pushReady,
  input  logic          slotEn,
  input  logic [3:0]    cmdLow,
  input  logic          cmdDma,
  input  logic          dmaEnable,
  input  logic          dmaDone,
  input  logic [7:0]    autoInc,
  input  logic          addrLoad,
  input  logic [AW-1:0] addrLoadValue,
  output logic [AW-1:0] curAddr,
  output logic          wrEn,
  output logic [1:0]    wrTarget,
  output logic          wrByte,
  output logic [AW-1:0] wrAddr,
  output logic [15:0]   wrData,
  output logic          slotUnused,
  output logic          dmaSlot,
  output logic          dmaRun,
  output logic [15:0]   fillValue,
  output logic [15:0]   statusWord
);
  swqStrobes_t   strobes;
  logic          headValid;
  logic          full;
  logic [TW-1:0] headTime;
  logic          headPartial;

  swq_ctrl #(.TW(TW)) uCtrl (
    .clk(clk), .rstN(rstN), .cycleNow(cycleNow), .pushValid(pushValid),
    .slotEn(slotEn), .cmdLow(cmdLow), .cmdDma(cmdDma), .dmaEnable(dmaEnable),
    .dmaDone(dmaDone), .headValid(headValid), .full(full), .headTime(headTime),
    .headPartial(headPartial), .strobes(strobes), .wrEn(wrEn),
    .wrTarget(wrTarget), .slotUnused(slotUnused), .dmaSlot(dmaSlot),
    .dmaRun(dmaRun)
  );

  swq_dp #(.DEPTH(DEPTH), .AW(AW), .TW(TW)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .pushData(pushData),
    .pushTime(pushTime), .autoInc(autoInc), .addrLoad(addrLoad),
    .addrLoadValue(addrLoadValue), .headValid(headValid), .full(full),
    .headTime(headTime), .headPartial(headPartial), .curAddr(curAddr),
    .wrAddr(wrAddr), .wrData(wrData), .fillValue(fillValue)
  );

  assign pushReady  = !full;
  assign wrByte     = strobes.wrByte;
  assign statusWord = {7'b0, full, 8'b0};
endmodule

// File: rtl/slot_write_queue_chk.sv
module slot_write_queue_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          pushReady,
  input logic          slotEn,
  input logic          addrLoad,
  input logic          dmaDone,
  input logic [AW-1:0] curAddr,
  input logic          wrEn,
  input logic [1:0]    wrTarget,
  input logic          wrByte,
  input logic [AW-1:0] wrAddr,
  input logic          slotUnused,
  input logic          dmaSlot,
  input logic          dmaRun,
  input logic [15:0]   statusWord
);
  AST_FULL_BLOCKS_PUSH: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[8] |-> !pushReady);  // R9
  AST_STATUS_OTHER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord & 16'hFEFF) == 16'h0);  // R8
  AST_NO_WRITE_IN_DMA: assert property (@(posedge clk) disable iff (!rstN)
    dmaRun |-> !wrEn);  // R7
  AST_DMA_OWNS_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    (dmaRun && slotEn) |-> (dmaSlot && !slotUnused));  // R7
  AST_UNUSED_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    slotUnused |-> !wrEn);  // R2
  AST_WRITE_NEEDS_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> slotEn);  // R2
  AST_FILL_KEEPS_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(dmaRun) && !$past(addrLoad)) |-> $stable(curAddr));  // R6
  AST_HIGH_BYTE_KEEPS_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrByte && wrTarget == 2'd0 && wrAddr == curAddr && !curAddr[0] && !addrLoad)
      |=> $stable(curAddr));  // R4
  AST_DONE_CLEARS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (dmaRun && dmaDone) |=> !dmaRun);  // R7
endmodule

bind slot_write_queue slot_write_queue_chk #(.AW(AW)) uChk (
  .clk(clk), .rstN(rstN), .pushReady(pushReady), .slotEn(slotEn),
  .addrLoad(addrLoad), .dmaDone(dmaDone), .curAddr(curAddr), .wrEn(wrEn),
  .wrTarget(wrTarget), .wrByte(wrByte), .wrAddr(wrAddr),
  .slotUnused(slotUnused), .dmaSlot(dmaSlot), .dmaRun(dmaRun),
  .statusWord(statusWord)
);

// File: tb/sim_slot_write_queue.sv
`timescale 1ns/1ps
module sim_slot_write_queue;
  localparam int AW = 16;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [TW-1:0] cycleNow = '0;
  logic          pushValid = 1'b0;
  logic [15:0]   pushData = '0;
  logic [TW-1:0] pushTime = '0;
  logic          pushReady;
  logic          slotEn = 1'b0;
  logic [3:0]    cmdLow = 4'd0;
  logic          cmdDma = 1'b0;
  logic          dmaEnable = 1'b0;
  logic          dmaDone = 1'b0;
  logic [7:0]    autoInc = 8'd2;
  logic          addrLoad = 1'b0;
  logic [AW-1:0] addrLoadValue = '0;
  logic [AW-1:0] curAddr;
  logic          wrEn;
  logic [1:0]    wrTarget;
  logic          wrByte;
  logic [AW-1:0] wrAddr;
  logic [15:0]   wrData;
  logic          slotUnused;
  logic          dmaSlot;
  logic          dmaRun;
  logic [15:0]   fillValue;
  logic [15:0]   statusWord;

  int checks = 0;
  int fails  = 0;
  int unusedSeen = 0;
  logic [TW-1:0] lastWrCycle = '0;
  logic [34:0] expQ[$];

  always #2 clk = ~clk;
  always @(posedge clk) cycleNow <= cycleNow + 1'b1;

  slot_write_queue u0 (.*);

  task automatic check(input string req, input logic [34:0] act, input logic [34:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expectWr(input logic [1:0] tgt, input logic b, input logic [15:0] a, input logic [15:0] d);
    expQ.push_back({tgt, b, a, d});
  endtask

  // monitor: compare every write against the scoreboard queue
  always @(negedge clk) begin
    if (rstN && slotUnused) unusedSeen++;
    if (rstN && wrEn) begin
      lastWrCycle = cycleNow;
      if (expQ.size() == 0) check("R11 unexpected write", {wrTarget, wrByte, wrAddr, wrData}, 35'h0);
      else check("R3/R4/R11 write", {wrTarget, wrByte, wrAddr, wrData}, expQ.pop_front());
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic loadAddr(input logic [15:0] a);
    addrLoad = 1'b1; addrLoadValue = a; tick(1); addrLoad = 1'b0;
  endtask

  task automatic push(input logic [15:0] d, input logic [TW-1:0] t);
    pushValid = 1'b1; pushData = d; pushTime = t; tick(1); pushValid = 1'b0;
  endtask

  initial begin
    fork
      begin
        #700000;
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
      end
    join_none

    tick(3);
    @(negedge clk);
    check("R1 status", 35'(statusWord), 35'h0);
    check("R1 pushReady/dmaRun/wrEn", {pushReady, dmaRun, wrEn}, 35'b100);
    check("R1 curAddr", 35'(curAddr), 35'h0);
    @(posedge clk); #1; rstN = 1'b1;
    tick(1);

    // R3 color and scroll words
    slotEn = 1'b1; autoInc = 8'd2;
    loadAddr(16'h0010);
    cmdLow = 4'd3;
    expectWr(2'd1, 1'b0, 16'h0010, 16'h1234);
    push(16'h1234, 0);
    tick(3);
    check("R3 address advanced", 35'(curAddr), 35'h12);
    cmdLow = 4'd5;
    expectWr(2'd2, 1'b0, 16'h0012, 16'hBEEF);
    push(16'hBEEF, 0);
    tick(3);
    check("R3 scroll advance", 35'(curAddr), 35'h14);

    // R4 pattern split, with gaps between slots
    loadAddr(16'h0020);
    cmdLow = 4'd1; slotEn = 1'b0;
    push(16'hABCD, 0);
    expectWr(2'd0, 1'b1, 16'h0020, 16'h00AB);
    expectWr(2'd0, 1'b1, 16'h0021, 16'h00CD);
    slotEn = 1'b1; tick(1); slotEn = 1'b0;
    tick(2);
    check("R4 address kept after high byte", 35'(curAddr), 35'h20);
    slotEn = 1'b1; tick(1); slotEn = 1'b0;
    tick(1);
    check("R4 address after low byte", 35'(curAddr), 35'h22);

    // R5 non-write command removes entry and advances
    cmdLow = 4'd0; slotEn = 1'b1;
    push(16'h5555, 0);
    tick(3);
    check("R5 address advanced, no write", 35'(curAddr), 35'h24);
    check("R5 queue empty", 35'(expQ.size()), 35'h0);

    // R2 ready time
    cmdLow = 4'd3;
    begin
      logic [TW-1:0] rt;
      rt = cycleNow + 16'd8;
      unusedSeen = 0;
      expectWr(2'd1, 1'b0, 16'h0024, 16'h0F0F);
      push(16'h0F0F, rt);
      tick(12);
      check("R2 write cycle equals ready time", 35'(lastWrCycle), 35'(rt));
      check("R2 unused slots seen", 35'(unusedSeen >= 6), 35'h1);
    end

    // R8/R9 fill to full, refused push, order
    slotEn = 1'b0;
    loadAddr(16'h0100);
    for (int k = 0; k < 4; k++) begin
      expectWr(2'd1, 1'b0, 16'h0100 + 16'(2*k), 16'hA000 + 16'(k));
      push(16'hA000 + 16'(k), 0);
    end
    @(negedge clk);
    check("R8 full status", 35'(statusWord), 35'h100);
    check("R9 pushReady low", 35'(pushReady), 35'h0);
    @(posedge clk); #1;
    push(16'hDEAD, 0);
    slotEn = 1'b1; tick(8);
    check("R9 refused push dropped", 35'(expQ.size()), 35'h0);
    check("R8 status clear", 35'(statusWord), 35'h0);
    check("R11 address after four", 35'(curAddr), 35'h108);

    // R6 with DMA disabled the bit is ignored
    cmdDma = 1'b1; dmaEnable = 1'b0;
    expectWr(2'd1, 1'b0, 16'h0108, 16'h1111);
    push(16'h1111, 0);
    tick(3);
    check("R6 ignored when disabled", {dmaRun, 34'(curAddr)}, {1'b0, 34'h10A});

    // R6/R7 fill start and hold
    dmaEnable = 1'b1;
    loadAddr(16'h0040);
    push(16'h5A5A, 0);
    tick(2);
    check("R6 run and fill", {dmaRun, 18'h0, fillValue}, {1'b1, 18'h0, 16'h5A5A});
    check("R6 address unchanged", 35'(curAddr), 35'h40);
    push(16'h7777, 0);
    tick(4);
    @(negedge clk);
    check("R7 dmaSlot and hold", {dmaSlot, slotUnused, wrEn}, 35'b100);
    @(posedge clk); #1;
    cmdDma = 1'b0;
    expectWr(2'd1, 1'b0, 16'h0040, 16'h7777);
    dmaDone = 1'b1; tick(1); dmaDone = 1'b0;
    tick(3);
    check("R7 run cleared", 35'(dmaRun), 35'h0);
    check("R7 held entry drained", 35'(expQ.size()), 35'h0);

    // R10 load priority over increment
    slotEn = 1'b0;
    push(16'h2222, 0);
    expectWr(2'd1, 1'b0, 16'h0042, 16'h2222);
    slotEn = 1'b1; addrLoad = 1'b1; addrLoadValue = 16'h0300;
    tick(1);
    addrLoad = 1'b0; slotEn = 1'b0;
    tick(1);
    check("R10 load wins", 35'(curAddr), 35'h300);

    tick(2);
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule